// File: doc/BRIEF.md
# Frame Header Field Extractor with Header CRC Check

This block sits behind a bit-level receiver that has already removed the byte start pairs from a frame. It takes one decoded bit per strobe, counting from the frame start bit, and shifts the 41 leading bits of the frame into fixed header fields. These fields are five single-bit indicators, an 11-bit frame identifier, a 7-bit payload length word, the 11-bit header checksum as received, and a 6-bit cycle counter. The payload byte count is derived from the length word.

While the bits arrive, a serial 11-bit checksum engine runs over the header bits from the sync indicator through the end of the length word. When the last cycle-counter bit has been taken in, the block compares its own checksum with the received one and screens the indicators and identifier for illegal combinations. It then raises a single-cycle completion pulse. Any strobes that follow are ignored until the receiver issues a frame-start clear. That clear also zeroes every field and flag, and the next strobe counts as bit 0. The checksum is computed the same way on both channels, so no channel selection exists.

Top module: `frame_header_parser`

## Requirements
- R1: After reset every field output, `pay_bytes`, `crc_ok`, `hdr_err` and `hdr_done` read zero.
- R2: A `frame_clr` pulse zeroes all fields and flags and drops `hdr_done`. The next `bit_vld` strobe is taken as bit 0. A strobe in the same cycle as `frame_clr` is discarded.
- R3: Bit 1 is stored in `flag_rsvd` and bit 2 in `flag_ppi`. Bit 3 is stored in `flag_data`, where 1 marks a data frame and 0 a null frame. Bit 4 is stored in `flag_sync` and bit 5 in `flag_startup`.
- R4: Bits 6..16 form `frame_id`, bits 17..23 form `pay_len`, bits 24..34 form `rx_crc` and bits 35..40 form `cycle_cnt`. Each field arrives MSB first.
- R5: `pay_bytes` equals twice `pay_len` (0 to 254).
- R6: The checksum is the 11-bit value with generator 0x385 and start value 0x01A. It is shifted MSB first over bits 4..23, with no final inversion. `crc_ok` is 1 exactly when this value equals `rx_crc`.
- R7: `hdr_err` is 1 when `frame_id` is 0, when `flag_startup` is 1 while `flag_sync` is 0, or when `flag_data` is 0 while `flag_ppi` is 1.
- R8: `hdr_done` is high for exactly one cycle, the cycle after the clock edge that captures bit 40. In that cycle `crc_ok`, `hdr_err` and all fields are valid, and they hold until the next `frame_clr`.
- R9: Strobes after bit 40 change no output and cause no further `hdr_done` until `frame_clr`.
- R10: Cycles without a strobe leave all fields unchanged, so any spacing of strobes gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clr | input | 1 | Frame-start clear; the next strobe is bit 0 |
| bit_vld | input | 1 | Strobe: one decoded frame bit this cycle |
| bit_val | input | 1 | Value of the strobed bit |
| flag_rsvd | output | 1 | Reserved bit (bit 1) |
| flag_ppi | output | 1 | Payload preamble indicator (bit 2) |
| flag_data | output | 1 | 1 = data frame, 0 = null frame (bit 3) |
| flag_sync | output | 1 | Sync indicator (bit 4) |
| flag_startup | output | 1 | Startup indicator (bit 5) |
| frame_id | output | ID_W | Frame identifier |
| pay_len | output | LEN_W | Payload length word |
| rx_crc | output | CRC_W | Header checksum as received |
| cycle_cnt | output | CYC_W | Cycle counter |
| pay_bytes | output | LEN_W+1 | Payload byte count (2 x pay_len) |
| crc_ok | output | 1 | Computed checksum matches received |
| hdr_err | output | 1 | Illegal identifier or indicator combination |
| hdr_done | output | 1 | One-cycle pulse: header complete |

## Verification
The bench builds the block with its default widths: an 11-bit identifier, a 7-bit length word, an 11-bit checksum with generator 0x385 and start value 0x01A, and a 6-bit cycle counter. Because the field positions follow from these widths, the defaults put the all-ones identifier 2047, the largest length 127 (254 bytes) and cycle 63 within reach. They also allow a corrupted checksum to be checked against the real generator. With these sizes every bit index, including the saturation point after bit 40, is driven by complete frames, frames with idle gaps, truncated frames and a clear that coincides with a strobe.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  // Positions of the single-bit indicators; their order is decoded downstream.
  localparam int POS_RSVD    = 1;
  localparam int POS_PPI     = 2;
  localparam int POS_DATA    = 3;
  localparam int POS_SYNC    = 4;
  localparam int POS_STARTUP = 5;
  localparam int FLAG_N      = POS_STARTUP - POS_RSVD + 1;
  // First bit of the identifier follows the indicators.
  localparam int ID_FIRST    = POS_STARTUP + 1;

  typedef struct packed {
    logic startup;
    logic sync;
    logic data;
    logic ppi;
    logic rsvd;
  } hdr_flags_t;
endpackage

// File: rtl/hdr_bit_index.sv
module hdr_bit_index #(
  parameter int LAST = 40,
  parameter int IW   = $clog2(LAST + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          stb,
  output logic [IW-1:0] idx,
  output logic          last_hit
);
  localparam logic [IW-1:0] LAST_I = IW'(LAST);
  localparam logic [IW-1:0] STOP_I = IW'(LAST + 1);

  logic live;
  assign live     = (idx <= LAST_I);
  assign last_hit = stb && !clr && (idx == LAST_I);

  always_ff @(posedge clk) begin
    if (rst || clr)
      idx <= '0;
    else if (stb && live)
      idx <= idx + 1'b1;
  end

  // R9: the index parks one past the last header bit
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= STOP_I);

  // R9: once parked, strobes do not move it
  idx_park_chk: assert property (@(posedge clk) disable iff (rst)
    (idx == STOP_I && !clr) |=> idx == STOP_I);
endmodule

// File: rtl/hdr_field_shift.sv
module hdr_field_shift #(
  parameter int W  = 11,
  parameter int LO = 6,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          stb,
  input  logic          din,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  val
);
  localparam logic [IW-1:0] LO_I = IW'(LO);
  localparam logic [IW-1:0] HI_I = IW'(LO + W - 1);

  logic take;
  assign take = stb && (idx >= LO_I) && (idx <= HI_I);

  always_ff @(posedge clk) begin
    if (rst || clr)
      val <= '0;
    else if (take)
      val <= {val[W-2:0], din};
  end
endmodule

// File: rtl/hdr_crc_serial.sv
module hdr_crc_serial #(
  parameter int W = 11,
  parameter logic [W-1:0] POLY = 11'h385,
  parameter logic [W-1:0] INIT = 11'h01A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic fb;
  assign fb = crc[W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc <= INIT;
    else if (en)
      crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  // R6: the register only moves on covered bits
  crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(crc));
endmodule

// File: rtl/frame_header_parser.sv
module frame_header_parser
  import hdr_pkg::*;
#(
  parameter int ID_W  = 11,
  parameter int LEN_W = 7,
  parameter int CRC_W = 11,
  parameter int CYC_W = 6,
  parameter logic [CRC_W-1:0] CRC_POLY = 11'h385,
  parameter logic [CRC_W-1:0] CRC_INIT = 11'h01A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_clr,
  input  logic             bit_vld,
  input  logic             bit_val,
  output logic             flag_rsvd,
  output logic             flag_ppi,
  output logic             flag_data,
  output logic             flag_sync,
  output logic             flag_startup,
  output logic [ID_W-1:0]  frame_id,
  output logic [LEN_W-1:0] pay_len,
  output logic [CRC_W-1:0] rx_crc,
  output logic [CYC_W-1:0] cycle_cnt,
  output logic [LEN_W:0]   pay_bytes,
  output logic             crc_ok,
  output logic             hdr_err,
  output logic             hdr_done
);
  localparam int LEN_LO  = ID_FIRST + ID_W;
  localparam int CRC_LO  = LEN_LO + LEN_W;
  localparam int CYC_LO  = CRC_LO + CRC_W;
  localparam int LAST    = CYC_LO + CYC_W - 1;
  localparam int COV_HI  = LEN_LO + LEN_W - 1;
  localparam int IW      = $clog2(LAST + 2);
  localparam logic [IW-1:0] COV_LO_I = IW'(POS_SYNC);
  localparam logic [IW-1:0] COV_HI_I = IW'(COV_HI);

  logic [IW-1:0]    idx;
  logic             last_hit;
  logic             stb;
  logic [CRC_W-1:0] crc_calc;
  hdr_flags_t       flg;

  assign stb = bit_vld && !frame_clr;

  hdr_bit_index #(.LAST(LAST), .IW(IW)) u_index (
    .clk(clk), .rst(rst), .clr(frame_clr), .stb(stb),
    .idx(idx), .last_hit(last_hit));

  // Indicator bits, one per fixed position
  always_ff @(posedge clk) begin
    if (rst || frame_clr)
      flg <= '0;
    else if (stb)
      for (int k = 0; k < FLAG_N; k++)
        if (idx == IW'(POS_RSVD + k)) flg[k] <= bit_val;
  end

  hdr_field_shift #(.W(ID_W), .LO(ID_FIRST), .IW(IW)) u_id (
    .clk(clk), .rst(rst), .clr(frame_clr), .stb(stb), .din(bit_val),
    .idx(idx), .val(frame_id));
  hdr_field_shift #(.W(LEN_W), .LO(LEN_LO), .IW(IW)) u_len (
    .clk(clk), .rst(rst), .clr(frame_clr), .stb(stb), .din(bit_val),
    .idx(idx), .val(pay_len));
  hdr_field_shift #(.W(CRC_W), .LO(CRC_LO), .IW(IW)) u_rcrc (
    .clk(clk), .rst(rst), .clr(frame_clr), .stb(stb), .din(bit_val),
    .idx(idx), .val(rx_crc));
  hdr_field_shift #(.W(CYC_W), .LO(CYC_LO), .IW(IW)) u_cyc (
    .clk(clk), .rst(rst), .clr(frame_clr), .stb(stb), .din(bit_val),
    .idx(idx), .val(cycle_cnt));

  logic crc_en;
  assign crc_en = stb && (idx >= COV_LO_I) && (idx <= COV_HI_I);

  hdr_crc_serial #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst(rst), .clr(frame_clr), .en(crc_en), .din(bit_val),
    .crc(crc_calc));

  // Verdicts are taken at the edge that captures the final header bit
  always_ff @(posedge clk) begin
    if (rst || frame_clr) begin
      hdr_done <= 1'b0;
      crc_ok   <= 1'b0;
      hdr_err  <= 1'b0;
    end else begin
      hdr_done <= last_hit;
      if (last_hit) begin
        crc_ok  <= (crc_calc == rx_crc);
        hdr_err <= (frame_id == '0) || (flg.startup && !flg.sync) ||
                   (!flg.data && flg.ppi);
      end
    end
  end

  assign flag_rsvd    = flg.rsvd;
  assign flag_ppi     = flg.ppi;
  assign flag_data    = flg.data;
  assign flag_sync    = flg.sync;
  assign flag_startup = flg.startup;
  assign pay_bytes    = {pay_len, 1'b0};

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> !hdr_done);

  // R8
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_done |-> $past(bit_vld));

  // R2
  clr_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    frame_clr |=> (!hdr_done && frame_id == '0 && !crc_ok && !hdr_err));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !frame_clr) |=> ($stable(frame_id) && $stable(cycle_cnt) &&
                                  $stable(rx_crc) && $stable(crc_ok)));
endmodule

// File: tb/test_frame_header_parser.sv
module test_frame_header_parser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_clr = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_val = 1'b0;
  logic flag_rsvd, flag_ppi, flag_data, flag_sync, flag_startup;
  logic [10:0] frame_id;
  logic [6:0]  pay_len;
  logic [10:0] rx_crc;
  logic [5:0]  cycle_cnt;
  logic [7:0]  pay_bytes;
  logic crc_ok, hdr_err, hdr_done;

  always #5 clk = ~clk;

  frame_header_parser i_frame_header_parser (
    .clk(clk), .rst(rst), .frame_clr(frame_clr), .bit_vld(bit_vld),
    .bit_val(bit_val), .flag_rsvd(flag_rsvd), .flag_ppi(flag_ppi),
    .flag_data(flag_data), .flag_sync(flag_sync), .flag_startup(flag_startup),
    .frame_id(frame_id), .pay_len(pay_len), .rx_crc(rx_crc),
    .cycle_cnt(cycle_cnt), .pay_bytes(pay_bytes), .crc_ok(crc_ok),
    .hdr_err(hdr_err), .hdr_done(hdr_done));

  typedef struct {
    logic [10:0] id;
    logic [6:0]  len;
    logic [10:0] crc;
    logic [5:0]  cyc;
    logic [4:0]  flg;
    logic        ok;
    logic        err;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int dones = 0;
  int frames = 0;
  bit finished = 0;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] crc_model(input logic [19:0] d);
    logic [10:0] r;
    r = 11'h01A;
    for (int i = 19; i >= 0; i--) begin
      logic fb;
      fb = r[10] ^ d[i];
      r = {r[9:0], 1'b0};
      if (fb) r = r ^ 11'h385;
    end
    return r;
  endfunction

  task automatic pulse_clr();
    @(negedge clk); frame_clr = 1'b1;
    @(negedge clk); frame_clr = 1'b0;
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk); bit_vld = 1'b1; bit_val = b;
    @(negedge clk); bit_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Driver: builds a header, pushes the expected result, shifts it out
  task automatic send_frame(input logic res, input logic ppi, input logic nf,
                            input logic sy, input logic su, input logic [10:0] id,
                            input logic [6:0] len, input logic [5:0] cyc,
                            input bit bad, input int gap, input bit do_clr);
    exp_t e;
    logic [10:0] c;
    logic [40:0] fr;
    c = crc_model({sy, su, id, len});
    if (bad) c = c ^ 11'h001;
    e.id = id; e.len = len; e.crc = c; e.cyc = cyc;
    e.flg = {su, sy, nf, ppi, res};
    e.ok = !bad;
    e.err = (id == 11'd0) || (su && !sy) || (!nf && ppi);
    if (do_clr) pulse_clr();
    q.push_back(e);
    frames++;
    fr = {1'b1, res, ppi, nf, sy, su, id, len, c, cyc};
    for (int i = 40; i >= 0; i--) send_bit(fr[i], gap);
  endtask

  // Monitor: compares each completed header with the scoreboard head
  always @(negedge clk) begin
    if (!rst && hdr_done) begin
      dones++;
      if (q.size() == 0) begin
        chk(0, "R8 unexpected hdr_done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(frame_id == e.id, "R4 frame_id", frame_id, e.id);
        chk(pay_len == e.len, "R4 pay_len", pay_len, e.len);
        chk(rx_crc == e.crc, "R4 rx_crc", rx_crc, e.crc);
        chk(cycle_cnt == e.cyc, "R4 cycle_cnt", cycle_cnt, e.cyc);
        chk({flag_startup, flag_sync, flag_data, flag_ppi, flag_rsvd} == e.flg,
            "R3 flags", {flag_startup, flag_sync, flag_data, flag_ppi, flag_rsvd}, e.flg);
        chk(pay_bytes == 8'(2 * e.len), "R5 pay_bytes", pay_bytes, 2 * e.len);
        chk(crc_ok == e.ok, "R6 crc_ok", crc_ok, e.ok);
        chk(hdr_err == e.err, "R7 hdr_err", hdr_err, e.err);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({frame_id, pay_len, rx_crc, cycle_cnt} == '0, "R1 fields zero",
        {frame_id, pay_len}, 0);
    chk({flag_rsvd, flag_ppi, flag_data, flag_sync, flag_startup, crc_ok,
         hdr_err, hdr_done, pay_bytes} == '0, "R1 flags zero", hdr_done, 0);

    send_frame(0, 1, 1, 1, 1, 11'h155, 7'd5, 6'd17, 0, 0, 1);   // R6 good
    @(negedge clk);
    chk(hdr_done == 1'b0, "R8 done single cycle", hdr_done, 0);
    chk(crc_ok == 1'b1, "R8 crc_ok held", crc_ok, 1);
    send_frame(0, 0, 1, 1, 0, 11'h2A3, 7'd9, 6'd40, 1, 0, 1);   // R6 bad
    send_frame(0, 0, 1, 0, 0, 11'h000, 7'd1, 6'd2, 0, 1, 1);    // R7 id zero
    send_frame(1, 0, 1, 0, 1, 11'h010, 7'd3, 6'd5, 0, 0, 1);    // R7 startup w/o sync
    send_frame(0, 1, 0, 1, 0, 11'h3C4, 7'd0, 6'd9, 0, 3, 1);    // R7/R10 null+ppi, gaps
    send_frame(1, 0, 1, 1, 0, 11'h7FF, 7'd127, 6'd63, 0, 0, 1); // R5 max
    send_frame(0, 0, 0, 0, 0, 11'h001, 7'd0, 6'd0, 0, 2, 1);    // R7 legal null

    // R9: extra strobes after the header
    d0 = dones;
    for (int i = 0; i < 6; i++) send_bit(1'b1, 0);
    repeat (2) @(negedge clk);
    chk(dones == d0, "R9 no extra done", dones, d0);
    chk(frame_id == 11'h001, "R9 frame_id unchanged", frame_id, 1);
    chk(cycle_cnt == 6'd0 && pay_len == 7'd0, "R9 fields unchanged", cycle_cnt, 0);
    chk(flag_data == 1'b0 && hdr_err == 1'b0, "R9 flags unchanged", hdr_err, 0);

    // R2: truncated frame, then clear wipes it
    pulse_clr();
    for (int i = 0; i < 20; i++) send_bit(1'b1, 0);
    chk(frame_id != 11'd0, "R2 partial capture", frame_id, 1);
    pulse_clr();
    chk(frame_id == 11'd0 && flag_sync == 1'b0 && crc_ok == 1'b0,
        "R2 clear zeroes", frame_id, 0);

    // R2: strobe coinciding with the clear is discarded
    @(negedge clk); frame_clr = 1'b1; bit_vld = 1'b1; bit_val = 1'b0;
    @(negedge clk); frame_clr = 1'b0; bit_vld = 1'b0;
    send_frame(0, 0, 1, 1, 1, 11'h4D2, 7'd64, 6'd33, 0, 0, 0);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8 all headers completed", q.size(), 0);
    chk(dones == frames, "R8 one done per frame", dones, frames);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule